// File: doc/BRIEF.md
# Strip Hit Finder with Masking

This block looks for particle hits in a stream of ADC samples from a silicon strip readout. Samples arrive one strip at a time, in strip order, and an event is `NSTRIP` strips long. Strip numbering starts at the channel bonded to index 0. For each strip the block subtracts a stored pedestal. It then compares the result with two cuts, each scaled by that strip's noise sigma. A strip that passes the higher seed cut is a hit. A strip directly next to a seed is also a hit if it passes the neighbour cut. Strips flagged bad are excluded, and so are strips whose noise is too high compared with the average noise.

Hits go into an output FIFO as a strip index and a signed amplitude. An end-of-event entry follows the last strip of every event. A raw mode skips the whole search and writes every strip with its unprocessed sample.

The per-strip pedestal, noise and bad flag live in tables that are loaded through a write port. The cuts and the average noise are static inputs. Decisions are delayed by one strip, so that both neighbours of a strip are known before that strip is accepted or dropped.

Top module: `strip_hit_finder`

## Requirements
- R1: The amplitude is `sample - pedestal` as a signed value. A strip is a seed when `amplitude*4 >= seed_cut*sigma`; the cuts carry 2 fractional bits. A strip whose amplitude equals the cut exactly still passes.
- R2: A non-seed strip is written only if it passes `amplitude*4 >= nbr_cut*sigma` and the strip at index i-1 or i+1 of the same event is a seed. A strip that passes only the neighbour cut and has no seed beside it is not written.
- R3: Each strip is written at most once per event, even when it sits between two seeds or is both a seed and a neighbour. Entries appear in ascending strip order.
- R4: A strip with its bad flag set is never written in hit mode, and it can serve neither as a seed nor as a neighbour.
- R5: A strip is excluded as noisy when `sigma*4 > noisy_cut*avg_noise` (noisy_cut has 2 fractional bits). An all-ones noisy_cut large enough to exceed every sigma turns this exclusion off.
- R6: Strips are numbered 0 to NSTRIP-1 in arrival order. Strip 0 has no left neighbour and strip NSTRIP-1 has no right neighbour, so neighbour acceptance never crosses from one event into the next.
- R7: After the entries of each event the FIFO receives exactly one end-of-event entry, with `out_eoe`=1, strip 0 and amplitude 0. Hit entries carry `out_eoe`=0.
- R8: With raw_mode=1, every strip is written with its unprocessed sample as the amplitude, whatever its pedestal, cuts or bad flag. The end-of-event entry is still written.
- R9: While `out_valid`=1 and `out_ready`=0, the head entry holds steady. `in_ready` drops when the FIFO is full and for the two cycles after the last strip of an event. No entry is ever lost.
- R10: After reset the FIFO is empty (`out_valid`=0), `in_ready`=1, and the next sample is taken as strip 0.
- R11: A table write with `tbl_we`=1 sets the pedestal, sigma and bad flag of strip `tbl_addr` at that clock edge, and later events use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | IDX_W | Strip written by the table port |
| tbl_ped | input | ADC_W | Pedestal value to store |
| tbl_noise | input | NOISE_W | Noise sigma to store (ADC units) |
| tbl_bad | input | 1 | Bad-strip flag to store |
| seed_cut | input | CUT_W | Seed cut in sigma, 2 fractional bits |
| nbr_cut | input | CUT_W | Neighbour cut in sigma, 2 fractional bits |
| noisy_cut | input | NCUT_W | Noisy-strip limit relative to average noise, 2 fractional bits |
| avg_noise | input | NOISE_W | Average noise sigma |
| raw_mode | input | 1 | 1: write every strip unprocessed |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_sample | input | ADC_W | ADC sample of the current strip |
| out_valid | output | 1 | FIFO head entry present |
| out_ready | input | 1 | Consumer takes the head entry |
| out_eoe | output | 1 | Head entry is the end-of-event marker |
| out_strip | output | IDX_W | Strip index of the head entry |
| out_amp | output | ADC_W+1 | Signed amplitude of the head entry |

## Verification
The bench targets the exact-threshold cases, where a `>` in place of `>=` would silently drop strips sitting on a cut. It also targets strips wedged between two seeds, where a double write would show up as a repeated index. Boundary events put a seed on the last strip and a neighbour-only strip on strip 0 of the next event. A design that carried the seed flag across events would write that stray neighbour, and one that forgot the final flush would lose the last strip or the end-of-event marker. Bad and noisy strips are placed both as would-be seeds and as would-be neighbours. The noisy limit is then opened to all ones to show the strip returning. Heavy backpressure on a small FIFO exposes lost or reordered entries.

// File: rtl/strip_hit_finder.sv
module strip_hit_finder #(
  parameter int NSTRIP  = 128,
  parameter int ADC_W   = 12,
  parameter int NOISE_W = 8,
  parameter int CUT_W   = 8,
  parameter int NCUT_W  = 12,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = $clog2(NSTRIP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_addr,
  input  logic [ADC_W-1:0]   tbl_ped,
  input  logic [NOISE_W-1:0] tbl_noise,
  input  logic               tbl_bad,
  input  logic [CUT_W-1:0]   seed_cut,
  input  logic [CUT_W-1:0]   nbr_cut,
  input  logic [NCUT_W-1:0]  noisy_cut,
  input  logic [NOISE_W-1:0] avg_noise,
  input  logic               raw_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADC_W-1:0]   in_sample,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_eoe,
  output logic [IDX_W-1:0]   out_strip,
  output logic signed [ADC_W:0] out_amp
);
  localparam int AMP_W = ADC_W + 1;
  localparam int PW    = ADC_W + CUT_W + NOISE_W + 3;
  localparam int NQ    = NOISE_W + NCUT_W + 2;
  localparam int ENT_W = 1 + IDX_W + AMP_W;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(NSTRIP - 1);
  localparam logic [AW:0]      FULLC = (AW+1)'(DEPTH);
  localparam logic [AW-1:0]    PTOP  = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_RUN, S_TAIL, S_EOE} st_t;

  logic [ADC_W-1:0]   ped_mem   [NSTRIP];
  logic [NOISE_W-1:0] noise_mem [NSTRIP];
  logic               bad_mem   [NSTRIP];

  always_ff @(posedge clk)
    if (tbl_we) begin
      ped_mem[tbl_addr]   <= tbl_ped;
      noise_mem[tbl_addr] <= tbl_noise;
      bad_mem[tbl_addr]   <= tbl_bad;
    end

  st_t              st;
  logic [IDX_W-1:0] idx, h_idx;
  logic signed [AMP_W-1:0] h_amp;
  logic h_raw, h_seed, h_nbr, l_seed;

  logic [ENT_W-1:0] fifo_mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      count;
  logic             full, accept, wr, rd;
  logic             take_run, take_tail, take_eoe;

  logic signed [AMP_W-1:0] amp, cur_amp;
  logic signed [PW-1:0]    amp4, seed_lim, nbr_lim;
  logic                    noisy, cur_ok, cur_seed, cur_nbr;

  assign amp      = $signed({1'b0, in_sample}) - $signed({1'b0, ped_mem[idx]});
  assign amp4     = PW'(amp) <<< 2;
  assign seed_lim = $signed(PW'(seed_cut) * PW'(noise_mem[idx]));
  assign nbr_lim  = $signed(PW'(nbr_cut) * PW'(noise_mem[idx]));
  assign noisy    = (NQ'(noise_mem[idx]) << 2) > NQ'(noisy_cut) * NQ'(avg_noise);
  assign cur_ok   = !bad_mem[idx] && !noisy;
  assign cur_seed = cur_ok && (amp4 >= seed_lim);
  assign cur_nbr  = cur_ok && (amp4 >= nbr_lim);
  assign cur_amp  = raw_mode ? $signed({1'b0, in_sample}) : amp;

  assign full     = (count == FULLC);
  assign in_ready = (st == S_RUN) && !full;
  assign accept   = in_valid && in_ready;

  assign take_run  = accept && (idx != '0) &&
                     (h_raw || h_seed || (h_nbr && (l_seed || cur_seed)));
  assign take_tail = (st == S_TAIL) && !full && (h_raw || h_seed || (h_nbr && l_seed));
  assign take_eoe  = (st == S_EOE) && !full;
  assign wr        = take_run || take_tail || take_eoe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RUN; idx <= '0; h_idx <= '0; h_amp <= '0;
      h_raw <= 1'b0; h_seed <= 1'b0; h_nbr <= 1'b0; l_seed <= 1'b0;
    end else if (accept) begin
      idx    <= (idx == LAST) ? '0 : idx + 1'b1;
      h_idx  <= idx;
      h_amp  <= cur_amp;
      h_raw  <= raw_mode;
      h_seed <= cur_seed;
      h_nbr  <= cur_nbr;
      l_seed <= (idx == '0) ? 1'b0 : h_seed;
      if (idx == LAST) st <= S_TAIL;
    end else if (st == S_TAIL && !full) begin
      st <= S_EOE;
    end else if (st == S_EOE && !full) begin
      st <= S_RUN;
    end
  end

  assign out_valid = (count != '0);
  assign rd        = out_valid && out_ready;
  assign {out_eoe, out_strip, out_amp} = fifo_mem[rp];

  always_ff @(posedge clk)
    if (wr) fifo_mem[wp] <= take_eoe ? {1'b1, {IDX_W{1'b0}}, {AMP_W{1'b0}}}
                                     : {1'b0, h_idx, h_amp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr) wp <= (wp == PTOP) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == PTOP) ? '0 : rp + 1'b1;
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);

  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_eoe, out_strip, out_amp}));

  p_flush_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && idx == LAST |=> st == S_TAIL && !in_ready);

  p_marker_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_EOE && !full |=> out_valid && st == S_RUN);

  p_no_idle_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RUN && !accept |=> count <= $past(count));
endmodule

// File: tb/strip_hit_finder_tb_top.sv
`timescale 1ns/1ps
module strip_hit_finder_tb_top;
  localparam int NS = 128, ADC = 12, NW = 8, CW = 8, NCW = 12, D = 8;
  localparam int EW = 1 + 7 + ADC + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 1'b0, tbl_bad = 1'b0;
  logic [6:0] tbl_addr = '0;
  logic [ADC-1:0] tbl_ped = '0;
  logic [NW-1:0] tbl_noise = '0;
  logic [CW-1:0] seed_cut = '0, nbr_cut = '0;
  logic [NCW-1:0] noisy_cut = '0;
  logic [NW-1:0] avg_noise = '0;
  logic raw_mode = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [ADC-1:0] in_sample = '0;
  logic in_ready, out_valid, out_eoe;
  logic [6:0] out_strip;
  logic signed [ADC:0] out_amp;

  strip_hit_finder #(.NSTRIP(NS), .ADC_W(ADC), .NOISE_W(NW), .CUT_W(CW),
                     .NCUT_W(NCW), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_ped(tbl_ped), .tbl_noise(tbl_noise), .tbl_bad(tbl_bad),
    .seed_cut(seed_cut), .nbr_cut(nbr_cut), .noisy_cut(noisy_cut),
    .avg_noise(avg_noise), .raw_mode(raw_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_sample(in_sample), .out_valid(out_valid),
    .out_ready(out_ready), .out_eoe(out_eoe), .out_strip(out_strip),
    .out_amp(out_amp));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0, rnd_ready = 1'b0;
  logic [EW-1:0] exp_q[$];
  string tag_q[$];
  int ped_m[NS], noise_m[NS], bad_m[NS], smp[NS];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void build_expect(string tag);
    bit sd[NS], nb[NS];
    for (int i = 0; i < NS; i++) begin
      int a = smp[i] - ped_m[i];
      bit ok = (bad_m[i] == 0) && !(noise_m[i] * 4 > int'(noisy_cut) * int'(avg_noise));
      sd[i] = ok && (a * 4 >= int'(seed_cut) * noise_m[i]);
      nb[i] = ok && (a * 4 >= int'(nbr_cut) * noise_m[i]);
    end
    for (int i = 0; i < NS; i++) begin
      bit adj = (i > 0 && sd[i-1]) || (i < NS - 1 && sd[i+1]);
      if (raw_mode || sd[i] || (nb[i] && adj)) begin
        int a = raw_mode ? smp[i] : smp[i] - ped_m[i];
        exp_q.push_back({1'b0, 7'(i), 13'(a)});
        tag_q.push_back(tag);
      end
    end
    exp_q.push_back({1'b1, 20'd0});
    tag_q.push_back("R7");
  endfunction

  task automatic load_tables();
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 7'(i); tbl_ped = ADC'(ped_m[i]);
      tbl_noise = NW'(noise_m[i]); tbl_bad = bad_m[i][0];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic send(int s);
    bit ok;
    in_valid = 1'b1; in_sample = ADC'(s);
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_event(string tag, bit gaps);
    build_expect(tag);
    for (int i = 0; i < NS; i++) begin
      if (gaps && ($urandom % 5 == 0)) @(negedge clk);
      send(smp[i]);
    end
    check(in_ready == 1'b0, "R9", "in_ready after last strip", int'(in_ready), 0);
  endtask

  task automatic base_tables(int pb);
    for (int i = 0; i < NS; i++) begin
      ped_m[i] = pb + (i % 5); noise_m[i] = 4; bad_m[i] = 0; smp[i] = ped_m[i];
    end
  endtask

  task automatic set_amp(int i, int a);
    smp[i] = ped_m[i] + a;
  endtask

  always @(negedge clk) begin
    out_ready = rnd_ready ? ($urandom % 3 == 0) : 1'b1;
    #1;
    if (out_valid && out_ready) begin
      logic [EW-1:0] got;
      got = {out_eoe, out_strip, out_amp};
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected entry", int'(got), 0);
      end else begin
        logic [EW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, t, "fifo entry {eoe,strip,amp}", int'(got), int'(e));
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9", "entries still missing", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);

    // R1 R2 R3 R6 R11: thresholds at exact cut, neighbours, boundaries
    base_tables(200);
    load_tables();
    seed_cut = 8'd16; nbr_cut = 8'd8; noisy_cut = '1; avg_noise = 8'd4; raw_mode = 1'b0;
    set_amp(0, 16); set_amp(1, 8); set_amp(9, 10); set_amp(10, 15);
    set_amp(11, 40); set_amp(12, 20); set_amp(13, 9); set_amp(15, 12);
    set_amp(40, -30); set_amp(126, 8); set_amp(127, 50);
    send_event("R1", 1'b0);
    drain();

    // R4: bad seed and bad neighbour
    bad_m[11] = 1; bad_m[13] = 1; bad_m[0] = 1;
    load_tables();
    send_event("R4", 1'b1);
    drain();

    // R5: noisy strip excluded, then exclusion disabled
    bad_m[11] = 0; bad_m[13] = 0; bad_m[0] = 0; noise_m[12] = 40;
    load_tables();
    set_amp(12, 500);
    noisy_cut = 12'd16;
    send_event("R5", 1'b0);
    drain();
    noisy_cut = '1;
    send_event("R5", 1'b0);
    drain();

    // R8: raw mode ignores bad flags and cuts
    bad_m[5] = 1; bad_m[11] = 1;
    load_tables();
    raw_mode = 1'b1;
    send_event("R8", 1'b1);
    drain();
    raw_mode = 1'b0;

    // R6: seed on last strip must not pull in strip 0 of next event
    base_tables(300);
    load_tables();
    set_amp(127, 60);
    send_event("R6", 1'b0);
    base_tables(300);
    set_amp(0, 10);
    send_event("R6", 1'b0);
    drain();

    // R9: dense hits under heavy backpressure
    rnd_ready = 1'b1;
    for (int i = 0; i < NS; i++) set_amp(i, (i % 3 == 0) ? 30 : 9);
    send_event("R9", 1'b0);
    drain();

    // R3: random tables, cuts and samples
    for (int ev = 0; ev < 10; ev++) begin
      for (int i = 0; i < NS; i++) begin
        int r = $urandom % 100;
        ped_m[i] = 50 + $urandom % 100;
        noise_m[i] = 1 + $urandom % 8;
        bad_m[i] = ($urandom % 20 == 0) ? 1 : 0;
        smp[i] = ped_m[i] - 20 + int'($urandom % 40) + ((r < 8) ? 30 + int'($urandom % 60) : 0);
      end
      load_tables();
      seed_cut = CW'(8 + $urandom % 16);
      nbr_cut = CW'(4 + $urandom % 8);
      noisy_cut = ($urandom % 2 == 0) ? '1 : NCW'(6 + $urandom % 6);
      avg_noise = NW'(2 + $urandom % 3);
      raw_mode = ($urandom % 6 == 0);
      rnd_ready = ($urandom % 2 == 0);
      send_event("R3", 1'b1);
    end
    rnd_ready = 1'b0;
    drain();
    finish_run();
  end
endmodule